// File: doc/BRIEF.md
# Autoprecharge Spacing and Power-Down Exit Monitor

This block watches the decoded command stream of a graphics DRAM and reports protocol breaches on it. Whenever a read or write with concurrent autoprecharge is issued to a bank, the block starts per-bank countdowns. Any later command to a *different* bank that comes too early is flagged. The minimum gap depends on what the earlier command was, and some gaps are formulas in the programmed read latency and write latency. The block also detects the edge at which the clock-enable line returns high after power-down. For the programmed exit-recovery interval after that edge, every command other than a no-operation or deselect is flagged.

The monitor is passive. It sits beside a memory controller or a bus model and drives a one-cycle violation pulse. The pulse carries a category code and the command that caused it. Same-bank timing and refresh timing are left to other checkers. Latency and recovery values come in as configuration inputs measured in clocks. They are expected to stay constant while traffic flows.

Top module: `gddr_ap_guard`

## Requirements
- R1: After reset the violation outputs are zero and no spacing window is open, so the first command after reset never raises a violation.
- R2: After a write-with-autoprecharge (code 7) to bank A, a read (4) or read-with-autoprecharge (5) to any bank other than A is flagged when it comes fewer than WL + 2 + tWTR clocks later.
- R3: After a write-with-autoprecharge to bank A, a write (6) or write-with-autoprecharge (7) to another bank is flagged when it comes fewer than 2 clocks later.
- R4: After a read-with-autoprecharge (5) to bank A, a read or read-with-autoprecharge to another bank is flagged when it comes fewer than 2 clocks later.
- R5: After a read-with-autoprecharge to bank A, a write or write-with-autoprecharge to another bank is flagged when it comes fewer than CL + 4 − WL clocks later. A negative result counts as zero.
- R6: An activate (2) or precharge (3) to another bank is never flagged for spacing, since its 1-clock minimum is always met.
- R7: Commands to the same bank as the tracked autoprecharge are never flagged for spacing.
- R8: A new autoprecharge command to a bank replaces that bank's earlier reference. The new limits apply from then on.
- R9: CKE sampled high on a rising edge after being sampled low marks power-down exit. A command other than NOP (0) or deselect (1) that arrives fewer than tXPN clocks after that edge, including at the edge itself, is flagged with the power-down category.
- R10: Commands sampled while CKE is low are ignored and never flagged.
- R11: A violation appears as viol_o high for exactly the cycle after the offending command's edge. viol_kind_o is 1 for spacing and 2 for power-down exit, and viol_cmd_o carries the offending command code. With no violation, both fields are 0.
- R12: When a command breaks both a spacing limit and the exit-recovery rule, the power-down category (2) is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock, commands sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| cke_i | input | 1 | Clock-enable line of the memory |
| cmd_i | input | 3 | Decoded command: 0 NOP, 1 DESEL, 2 ACT, 3 PRE, 4 RD, 5 RDA, 6 WR, 7 WRA |
| bank_i | input | BANK_W (2) | Bank address of the command |
| cfg_cl | input | CFG_W (5) | Read latency in clocks |
| cfg_wl | input | CFG_W (5) | Write latency in clocks |
| cfg_twtr | input | CFG_W (5) | Write-to-read turnaround in clocks |
| cfg_txpn | input | CFG_W (5) | Power-down exit recovery in clocks |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_kind_o | output | 2 | 0 none, 1 spacing, 2 power-down exit |
| viol_cmd_o | output | 3 | Command code that caused the violation |

## Verification
The checker assumes that cmd_i, bank_i and CKE are settled at each rising edge, and that the four configuration inputs stay constant between resets. The bench therefore drives every input on the falling edge. It programs the configuration once, before reset is released. Between scenarios the bench waits longer than the largest possible countdown, so each scenario starts with all windows closed. Each test places commands at gaps exactly one clock below and exactly at every limit.

// File: rtl/apg_pkg.sv
package apg_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_DES  = 3'd1,
    CMD_ACT  = 3'd2,
    CMD_PRE  = 3'd3,
    CMD_RD   = 3'd4,
    CMD_RDA  = 3'd5,
    CMD_WR   = 3'd6,
    CMD_WRA  = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_SPACE = 2'd1,
    KIND_PDX   = 2'd2
  } kind_e;

  // class index of a follower command
  localparam int CLS_RD = 0;
  localparam int CLS_WR = 1;
  localparam int CLS_PA = 2;
  localparam int NCLS   = 3;

endpackage

// File: rtl/apg_limits.sv
module apg_limits #(
  parameter int CFG_W = 5,
  parameter int CNT_W = CFG_W + 2
) (
  input  logic [CFG_W-1:0]                 cfg_cl,
  input  logic [CFG_W-1:0]                 cfg_wl,
  input  logic [CFG_W-1:0]                 cfg_twtr,
  output logic [apg_pkg::NCLS-1:0][CNT_W-1:0] rda_ld,
  output logic [apg_pkg::NCLS-1:0][CNT_W-1:0] wra_ld
);
  import apg_pkg::*;

  // a gap of N clocks becomes a countdown preset of N-1
  function automatic logic [CNT_W-1:0] preset(input logic [CNT_W-1:0] gap);
    return (gap == '0) ? '0 : gap - CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cl_x, wl_x, twtr_x;
  logic [CNT_W-1:0] wra_rd_gap, rda_wr_gap;

  always_comb begin
    cl_x   = CNT_W'(cfg_cl);
    wl_x   = CNT_W'(cfg_wl);
    twtr_x = CNT_W'(cfg_twtr);
    wra_rd_gap = wl_x + CNT_W'(2) + twtr_x;
    if (cl_x + CNT_W'(4) > wl_x) rda_wr_gap = cl_x + CNT_W'(4) - wl_x;
    else                        rda_wr_gap = '0;

    wra_ld[CLS_RD] = preset(wra_rd_gap);
    wra_ld[CLS_WR] = preset(CNT_W'(2));
    wra_ld[CLS_PA] = preset(CNT_W'(1));
    rda_ld[CLS_RD] = preset(CNT_W'(2));
    rda_ld[CLS_WR] = preset(rda_wr_gap);
    rda_ld[CLS_PA] = preset(CNT_W'(1));
  end

endmodule

// File: rtl/apg_bank_timer.sv
module apg_bank_timer #(
  parameter int CNT_W = 7
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 ld_rda,
  input  logic                                 ld_wra,
  input  logic [apg_pkg::NCLS-1:0][CNT_W-1:0]  rda_ld,
  input  logic [apg_pkg::NCLS-1:0][CNT_W-1:0]  wra_ld,
  output logic [apg_pkg::NCLS-1:0]             busy
);
  import apg_pkg::*;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (rst)          cnt <= '0;
      else if (ld_wra)  cnt <= wra_ld[c];
      else if (ld_rda)  cnt <= rda_ld[c];
      else if (cnt != '0) cnt <= cnt - CNT_W'(1);
    end

    assign busy[c] = (cnt != '0);
  end

endmodule

// File: rtl/apg_pdx_tracker.sv
module apg_pdx_tracker #(
  parameter int CFG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke_i,
  input  logic [CFG_W-1:0] cfg_txpn,
  output logic             block_o
);
  logic             cke_q;
  logic             exit_now;
  logic [CFG_W-1:0] cnt;

  assign exit_now = cke_i & ~cke_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q <= 1'b1;
      cnt   <= '0;
    end else begin
      cke_q <= cke_i;
      if (exit_now)        cnt <= (cfg_txpn == '0) ? '0 : cfg_txpn - CFG_W'(1);
      else if (cnt != '0)  cnt <= cnt - CFG_W'(1);
    end
  end

  // blocked at the exit edge itself and while the countdown runs
  assign block_o = (exit_now && cfg_txpn != '0) || (cnt != '0);

endmodule

// File: rtl/gddr_ap_guard.sv
module gddr_ap_guard #(
  parameter int BANKS  = 4,
  parameter int BANK_W = $clog2(BANKS),
  parameter int CFG_W  = 5,
  parameter int CNT_W  = CFG_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke_i,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [CFG_W-1:0]  cfg_cl,
  input  logic [CFG_W-1:0]  cfg_wl,
  input  logic [CFG_W-1:0]  cfg_twtr,
  input  logic [CFG_W-1:0]  cfg_txpn,
  output logic              viol_o,
  output logic [1:0]        viol_kind_o,
  output logic [2:0]        viol_cmd_o
);
  import apg_pkg::*;

  cmd_e cmd;
  assign cmd = cmd_e'(cmd_i);

  logic [NCLS-1:0][CNT_W-1:0] rda_ld, wra_ld;
  logic [BANKS-1:0][NCLS-1:0] busy;
  logic                       pdx_block;

  apg_limits #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_lim (
    .cfg_cl  (cfg_cl),
    .cfg_wl  (cfg_wl),
    .cfg_twtr(cfg_twtr),
    .rda_ld  (rda_ld),
    .wra_ld  (wra_ld)
  );

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic hit;
    assign hit = cke_i && (bank_i == BANK_W'(g));
    apg_bank_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk   (clk),
      .rst   (rst),
      .ld_rda(hit && cmd == CMD_RDA),
      .ld_wra(hit && cmd == CMD_WRA),
      .rda_ld(rda_ld),
      .wra_ld(wra_ld),
      .busy  (busy[g])
    );
  end

  apg_pdx_tracker #(.CFG_W(CFG_W)) u_pdx (
    .clk     (clk),
    .rst     (rst),
    .cke_i   (cke_i),
    .cfg_txpn(cfg_txpn),
    .block_o (pdx_block)
  );

  // windows held open by banks other than the addressed one
  logic [NCLS-1:0] other_busy;
  always_comb begin
    other_busy = '0;
    for (int g = 0; g < BANKS; g++) begin
      if (bank_i != BANK_W'(g)) other_busy |= busy[g];
    end
  end

  logic space_hit, pdx_hit, real_cmd;
  always_comb begin
    real_cmd = !(cmd == CMD_NOP || cmd == CMD_DES);
    unique case (cmd)
      CMD_RD,  CMD_RDA: space_hit = other_busy[CLS_RD];
      CMD_WR,  CMD_WRA: space_hit = other_busy[CLS_WR];
      CMD_ACT, CMD_PRE: space_hit = other_busy[CLS_PA];
      default:          space_hit = 1'b0;
    endcase
    space_hit = space_hit && cke_i;
    pdx_hit   = cke_i && real_cmd && pdx_block;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_o      <= 1'b0;
      viol_kind_o <= KIND_NONE;
      viol_cmd_o  <= CMD_NOP;
    end else if (pdx_hit) begin
      viol_o      <= 1'b1;
      viol_kind_o <= KIND_PDX;
      viol_cmd_o  <= cmd_i;
    end else if (space_hit) begin
      viol_o      <= 1'b1;
      viol_kind_o <= KIND_SPACE;
      viol_cmd_o  <= cmd_i;
    end else begin
      viol_o      <= 1'b0;
      viol_kind_o <= KIND_NONE;
      viol_cmd_o  <= CMD_NOP;
    end
  end

endmodule

// File: rtl/apg_checker.sv
module apg_checker (
  input logic       clk,
  input logic       rst,
  input logic       cke_i,
  input logic [2:0] cmd_i,
  input logic       viol_o,
  input logic [1:0] viol_kind_o,
  input logic [2:0] viol_cmd_o
);

  // R11
  pulse_has_kind_chk: assert property (@(posedge clk) disable iff (rst)
    viol_o |-> (viol_kind_o == 2'd1 || viol_kind_o == 2'd2));

  // R11
  quiet_fields_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !viol_o |-> (viol_kind_o == 2'd0 && viol_cmd_o == 3'd0));

  // R11
  cmd_echo_chk: assert property (@(posedge clk) disable iff (rst)
    viol_o |-> viol_cmd_o == $past(cmd_i));

  // R10
  cke_low_silent_chk: assert property (@(posedge clk) disable iff (rst)
    !cke_i |=> !viol_o);

  // R9
  idle_cmd_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == 3'd0 || cmd_i == 3'd1) |=> !viol_o);

endmodule

bind gddr_ap_guard apg_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .cke_i      (cke_i),
  .cmd_i      (cmd_i),
  .viol_o     (viol_o),
  .viol_kind_o(viol_kind_o),
  .viol_cmd_o (viol_cmd_o)
);

// File: tb/gddr_ap_guard_test.sv
module gddr_ap_guard_test;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd2, PRE = 3'd3, RD = 3'd4,
                         RDA = 3'd5, WR = 3'd6, WRA = 3'd7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke = 1'b1;
  logic [2:0] cmd = NOP;
  logic [1:0] bank = 2'd0;
  logic       viol;
  logic [1:0] kind;
  logic [2:0] vcmd;

  int checks = 0;
  int failures = 0;
  logic       s_v;
  logic [1:0] s_k;
  logic [2:0] s_c;

  always #2 clk = ~clk;

  gddr_ap_guard uut (
    .clk(clk), .rst(rst), .cke_i(cke), .cmd_i(cmd), .bank_i(bank),
    .cfg_cl(5'd7), .cfg_wl(5'd3), .cfg_twtr(5'd2), .cfg_txpn(5'd4),
    .viol_o(viol), .viol_kind_o(kind), .viol_cmd_o(vcmd)
  );

  // limits: WRA->RD 7, WRA->WR 2, RDA->RD 2, RDA->WR 8, tXPN 4

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // drive at a falling edge, capture the outputs one cycle later
  task automatic issue(input logic [2:0] c, input logic [1:0] b);
    cmd = c; bank = b;
    @(negedge clk);
    s_v = viol; s_k = kind; s_c = vcmd;
    cmd = NOP;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic ev,
                            input logic [1:0] ek, input logic [2:0] ec);
    checks++;
    if (s_v !== ev || s_k !== ek || s_c !== ec) begin
      failures++;
      $display("FAIL %s: got v=%0b kind=%0d cmd=%0d, want v=%0b kind=%0d cmd=%0d",
               req, s_v, s_k, s_c, ev, ek, ec);
    end
  endtask

  task automatic t_reset();
    s_v = viol; s_k = kind; s_c = vcmd;
    expect_out("R1 reset outputs", 1'b0, 2'd0, 3'd0);
    issue(RD, 2'd1);
    expect_out("R1 first command clean", 1'b0, 2'd0, 3'd0);
    idle(80);
  endtask

  task automatic t_wra_rd();
    issue(WRA, 2'd0); idle(5); issue(RD, 2'd1);
    expect_out("R2 RD 6 clk after WRA", 1'b1, 2'd1, RD);
    idle(80);
    issue(WRA, 2'd0); idle(6); issue(RDA, 2'd2);
    expect_out("R2 RDA 7 clk after WRA", 1'b0, 2'd0, 3'd0);
    idle(80);
  endtask

  task automatic t_wra_wr();
    issue(WRA, 2'd0); issue(WR, 2'd1);
    expect_out("R3 WR 1 clk after WRA", 1'b1, 2'd1, WR);
    idle(80);
    issue(WRA, 2'd0); idle(1); issue(WRA, 2'd1);
    expect_out("R3 WRA 2 clk after WRA", 1'b0, 2'd0, 3'd0);
    idle(80);
  endtask

  task automatic t_rda_rd();
    issue(RDA, 2'd2); issue(RD, 2'd3);
    expect_out("R4 RD 1 clk after RDA", 1'b1, 2'd1, RD);
    idle(80);
    issue(RDA, 2'd2); idle(1); issue(RD, 2'd3);
    expect_out("R4 RD 2 clk after RDA", 1'b0, 2'd0, 3'd0);
    idle(80);
  endtask

  task automatic t_rda_wr();
    issue(RDA, 2'd0); idle(6); issue(WR, 2'd1);
    expect_out("R5 WR 7 clk after RDA", 1'b1, 2'd1, WR);
    idle(80);
    issue(RDA, 2'd0); idle(7); issue(WR, 2'd1);
    expect_out("R5 WR 8 clk after RDA", 1'b0, 2'd0, 3'd0);
    idle(80);
  endtask

  task automatic t_pre_act_same();
    issue(WRA, 2'd0); issue(PRE, 2'd1);
    expect_out("R6 PRE 1 clk after WRA", 1'b0, 2'd0, 3'd0);
    idle(80);
    issue(RDA, 2'd0); issue(ACT, 2'd1);
    expect_out("R6 ACT 1 clk after RDA", 1'b0, 2'd0, 3'd0);
    idle(80);
    issue(WRA, 2'd0); issue(RD, 2'd0);
    expect_out("R7 same bank RD", 1'b0, 2'd0, 3'd0);
    idle(80);
  endtask

  task automatic t_replace();
    issue(WRA, 2'd0); issue(RDA, 2'd0); idle(1); issue(RD, 2'd1);
    expect_out("R8 newer RDA replaces WRA", 1'b0, 2'd0, 3'd0);
    issue(WR, 2'd2);
    expect_out("R8 RDA write window applies", 1'b1, 2'd1, WR);
    idle(80);
  endtask

  task automatic t_pdx();
    cke = 1'b0; idle(3);
    cke = 1'b1; issue(ACT, 2'd0);
    expect_out("R9 ACT at exit edge", 1'b1, 2'd2, ACT);
    idle(80);
    cke = 1'b0; idle(3);
    cke = 1'b1; issue(NOP, 2'd0); idle(2); issue(ACT, 2'd1);
    expect_out("R9 ACT 3 clk after exit", 1'b1, 2'd2, ACT);
    idle(80);
    cke = 1'b0; idle(3);
    cke = 1'b1; issue(NOP, 2'd0); idle(3); issue(ACT, 2'd1);
    expect_out("R9 ACT 4 clk after exit", 1'b0, 2'd0, 3'd0);
    idle(80);
  endtask

  task automatic t_cke_low();
    cke = 1'b0;
    issue(WRA, 2'd0);
    expect_out("R10 WRA while CKE low", 1'b0, 2'd0, 3'd0);
    issue(WR, 2'd1);
    expect_out("R10 WR while CKE low", 1'b0, 2'd0, 3'd0);
    cke = 1'b1; idle(80);
  endtask

  task automatic t_priority();
    cke = 1'b0; idle(3);
    cke = 1'b1; issue(NOP, 2'd0); issue(WRA, 2'd0);
    expect_out("R11 WRA in recovery, code and echo", 1'b1, 2'd2, WRA);
    issue(WR, 2'd1);
    expect_out("R12 both rules broken", 1'b1, 2'd2, WR);
    s_v = viol; s_k = kind; s_c = vcmd;
    @(negedge clk); s_v = viol; s_k = kind; s_c = vcmd;
    expect_out("R11 pulse lasts one cycle", 1'b0, 2'd0, 3'd0);
    idle(80);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout, want completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_wra_rd();
    t_wra_wr();
    t_rda_rd();
    t_rda_wr();
    t_pre_act_same();
    t_replace();
    t_pdx();
    t_cke_low();
    t_priority();
    finish_run();
  end

endmodule